// File: doc/BRIEF.md
# Serial Flash Address Mode Controller

This block forms addresses inside the command decoder of a serial NOR flash slave. A byte-level SPI front end hands it one byte per `byte_valid` pulse while `cs_n` is low. The first byte of each select window is the opcode. The block decides how many address bytes follow that opcode. It assembles them into a 32-bit start address and raises a one-cycle strobe that carries the opcode and the address to the memory sequencer.

There are three ways to reach the upper half of a 256 Mbit array. The first is a sticky 4-byte address mode. The second is a one-bit volatile extension register that supplies A24 while the device is in 3-byte mode. The third is a set of dedicated opcodes that always take four address bytes, whatever the current mode. The block also keeps the write-enable latch, which guards writes to the extension register, and it returns the extension register's value when software reads it.

Top module: `flash_addr_ctrl`

## Requirements
- R1: After a synchronous reset the block is in 3-byte mode (`addr4_mode`=0), the extension bit is 0, `wel`=0, and `cmd_valid` and `rd_valid` are low.
- R2: Opcode B7h sets `addr4_mode` and opcode E9h clears it. Neither needs the write-enable latch, and neither changes it.
- R3: In 3-byte mode the address-taking legacy opcodes take three address bytes, most significant first. These opcodes are 03h, 0Bh, 3Bh, BBh, 6Bh, EBh, 02h, 38h, 20h, 52h and D8h. The resulting address is {7'b0, extension bit, A23..A0}.
- R4: In 4-byte mode the legacy opcodes take four address bytes, A31 down to A0. The extension bit is ignored.
- R5: Opcodes 13h, 0Ch, 3Ch, BCh, 6Ch, ECh, 12h, 3Eh, 21h, DCh and 5Ch take four address bytes in either mode.
- R6: Opcode 06h sets `wel` and opcode 04h clears it.
- R7: Opcode C5h writes bit 0 of the byte that follows it into the extension bit, and then clears `wel`. This happens only if `wel` is already set. With `wel` clear, the data byte changes nothing.
- R8: Opcode C8h makes `rd_valid` pulse for one cycle, in the cycle after the opcode byte. At the same time `rd_data` carries the extension register value.
- R9: Bits 7..1 of the extension register always read as 0. Writes to them are ignored.
- R10: If `cs_n` rises before the last address byte arrives, the command is dropped. No strobe is raised and no state changes, and the next select window starts cleanly with an opcode.
- R11: `cmd_valid` pulses for one cycle, in the cycle after the final address byte. At the same time `cmd_opcode` and `cmd_addr` hold the command.
- R12: The block ignores bytes in two cases until `cs_n` rises. The first case is bytes that follow a complete command. The second is bytes that follow an opcode it does not handle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low during a command |
| byte_valid | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle strobe for an accepted address command |
| cmd_opcode | output | 8 | Opcode of the accepted command |
| cmd_addr | output | 32 | Start address of the accepted command |
| rd_valid | output | 1 | One-cycle strobe for an extension register read |
| rd_data | output | 8 | Extension register value |
| addr4_mode | output | 1 | 1 when the device is in 4-byte address mode |
| wel | output | 1 | Write-enable latch |

## Verification
Some rules hold on every cycle, and the embedded assertions check those:
- The extension bit can change only while `wel` is set, and `wel` is cleared by the same edge that changes it.
- The mode flag moves only on an enter or exit event.
- Reserved read bits are zero.
- A 3-byte address never has A31..A25 set.
- The sequencer always returns to the opcode state after a deselect.

Other behaviour appears only across whole select windows, so the scoreboard scenarios show it:
- how many address bytes each opcode takes in each mode;
- that dedicated opcodes ignore the mode;
- that truncated commands are dropped;
- that trailing and unknown bytes are ignored.

// File: rtl/fac_pkg.sv
// Shared opcode classification for the flash address mode controller.
// Assumes 8-bit opcodes; every opcode that is not listed is ignored.
package fac_pkg;

    typedef struct packed {
        logic takes_addr;  // opcode is followed by address bytes
        logic force_wide;  // always four address bytes
        logic go_wide;     // enter 4-byte mode
        logic go_narrow;   // leave 4-byte mode
        logic set_wel;
        logic clr_wel;
        logic ext_write;   // next byte is the extension register value
        logic ext_read;
    } op_class_t;

    function automatic op_class_t classify(input logic [7:0] op);
        op_class_t c;
        c = '0;
        case (op)
            8'h03, 8'h0B, 8'h3B, 8'hBB, 8'h6B, 8'hEB,
            8'h02, 8'h38, 8'h20, 8'h52, 8'hD8: c.takes_addr = 1'b1;
            8'h13, 8'h0C, 8'h3C, 8'hBC, 8'h6C, 8'hEC,
            8'h12, 8'h3E, 8'h21, 8'hDC, 8'h5C: begin
                c.takes_addr = 1'b1;
                c.force_wide = 1'b1;
            end
            8'hB7: c.go_wide   = 1'b1;
            8'hE9: c.go_narrow = 1'b1;
            8'h06: c.set_wel   = 1'b1;
            8'h04: c.clr_wel   = 1'b1;
            8'hC5: c.ext_write = 1'b1;
            8'hC8: c.ext_read  = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fac_seq.sv
// Byte sequencer: classifies the opcode, counts address bytes and emits
// single-cycle events. Assumes one byte per byte_valid while cs_n is low;
// a high cs_n drops any command in progress.
module fac_seq
    import fac_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int NARROW_CNT = 3,
    parameter int WIDE_CNT   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       byte_valid,
    input  logic [BYTE_W-1:0]          byte_data,
    input  logic                       mode_wide,
    output logic                       ev_go_wide,
    output logic                       ev_go_narrow,
    output logic                       ev_set_wel,
    output logic                       ev_clr_wel,
    output logic                       ev_ext_data,
    output logic                       ev_ext_read,
    output logic                       ev_addr_done,
    output logic                       done_wide,
    output logic [BYTE_W-1:0]          done_op,
    output logic [BYTE_W*WIDE_CNT-1:0] done_raw
);
    localparam int ADDR_W = BYTE_W * WIDE_CNT;
    localparam int CNT_W  = $clog2(WIDE_CNT + 1);

    typedef enum logic [1:0] {S_OP, S_ADDR, S_DATA, S_SKIP} st_t;

    st_t               st_q;
    logic [CNT_W-1:0]  cnt_q, need_q;
    logic [ADDR_W-1:0] sh_q;
    logic [BYTE_W-1:0] op_q;
    logic              wide_q;
    op_class_t         cls;
    logic              take;
    logic              last_addr;

    // Classify the incoming byte as an opcode.
    always_comb cls = classify(byte_data);

    assign take      = byte_valid && !cs_n;
    assign last_addr = (st_q == S_ADDR) && (cnt_q == need_q - 1'b1);

    // Produce the event pulses for the current byte.
    always_comb begin
        ev_go_wide   = take && (st_q == S_OP) && cls.go_wide;
        ev_go_narrow = take && (st_q == S_OP) && cls.go_narrow;
        ev_set_wel   = take && (st_q == S_OP) && cls.set_wel;
        ev_clr_wel   = take && (st_q == S_OP) && cls.clr_wel;
        ev_ext_read  = take && (st_q == S_OP) && cls.ext_read;
        ev_ext_data  = take && (st_q == S_DATA);
        ev_addr_done = take && last_addr;
        done_wide    = wide_q;
        done_op      = op_q;
        done_raw     = {sh_q[ADDR_W-BYTE_W-1:0], byte_data};
    end

    // Advance the command state and shift in the address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            st_q   <= S_OP;
            cnt_q  <= '0;
            need_q <= '0;
            sh_q   <= '0;
            op_q   <= '0;
            wide_q <= 1'b0;
        end else if (byte_valid) begin
            case (st_q)
                S_OP: begin
                    op_q  <= byte_data;
                    sh_q  <= '0;
                    cnt_q <= '0;
                    if (cls.takes_addr) begin
                        st_q   <= S_ADDR;
                        wide_q <= cls.force_wide || mode_wide;
                        need_q <= (cls.force_wide || mode_wide) ?
                                  CNT_W'(WIDE_CNT) : CNT_W'(NARROW_CNT);
                    end else if (cls.ext_write) begin
                        st_q <= S_DATA;
                    end else begin
                        st_q <= S_SKIP;
                    end
                end
                S_ADDR: begin
                    sh_q  <= {sh_q[ADDR_W-BYTE_W-1:0], byte_data};
                    cnt_q <= cnt_q + 1'b1;
                    if (last_addr) st_q <= S_SKIP;
                end
                S_DATA:  st_q <= S_SKIP;
                default: st_q <= S_SKIP;
            endcase
        end
    end

    // R10: a deselect always returns the sequencer to opcode state.
    assert_deselect_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st_q == S_OP));

    // R12: once a command is done, no further events occur until deselect.
    assert_skip_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SKIP) |-> !(ev_addr_done || ev_ext_data || ev_go_wide || ev_set_wel));

endmodule

// File: rtl/fac_regs.sv
// Mode, write-enable latch and extension register state.
// Assumes event pulses from fac_seq; only bit 0 of the extension register is stored.
module fac_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_go_wide,
    input  logic              ev_go_narrow,
    input  logic              ev_set_wel,
    input  logic              ev_clr_wel,
    input  logic              ev_ext_data,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              mode_wide,
    output logic              wel_q,
    output logic              ext_a24
);
    // Update the mode flag, the latch and the extension bit from events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_wide <= 1'b0;
            wel_q     <= 1'b0;
            ext_a24   <= 1'b0;
        end else begin
            if (ev_go_wide)   mode_wide <= 1'b1;
            if (ev_go_narrow) mode_wide <= 1'b0;
            if (ev_set_wel)   wel_q     <= 1'b1;
            if (ev_clr_wel)   wel_q     <= 1'b0;
            if (ev_ext_data && wel_q) begin
                ext_a24 <= byte_data[0];
                wel_q   <= 1'b0;
            end
        end
    end

    // R7: the extension bit holds while the latch is clear.
    assert_ext_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_q |=> $stable(ext_a24));

    // R7: a write that changes the extension bit also clears the latch.
    assert_write_clears_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ext_data && wel_q) |=> !wel_q);

    // R2: the mode flag changes only on an enter or exit opcode.
    assert_mode_needs_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_go_wide && !ev_go_narrow) |=> $stable(mode_wide));

endmodule

// File: rtl/fac_out.sv
// Output stage: registers the command strobe with its formed address and the
// register read strobe. Assumes raw holds the last WIDE_CNT bytes received.
module fac_out #(
    parameter int BYTE_W     = 8,
    parameter int NARROW_CNT = 3,
    parameter int WIDE_CNT   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_addr_done,
    input  logic                       done_wide,
    input  logic [BYTE_W-1:0]          done_op,
    input  logic [BYTE_W*WIDE_CNT-1:0] done_raw,
    input  logic                       ev_ext_read,
    input  logic                       ext_a24,
    output logic                       cmd_valid,
    output logic [BYTE_W-1:0]          cmd_opcode,
    output logic [BYTE_W*WIDE_CNT-1:0] cmd_addr,
    output logic                       rd_valid,
    output logic [BYTE_W-1:0]          rd_data
);
    localparam int ADDR_W = BYTE_W * WIDE_CNT;
    localparam int LOW_W  = BYTE_W * NARROW_CNT;

    logic [ADDR_W-1:0] formed;

    // Choose between the full address and the extended narrow address.
    always_comb begin
        if (done_wide) formed = done_raw;
        else           formed = {{(ADDR_W-LOW_W-1){1'b0}}, ext_a24, done_raw[LOW_W-1:0]};
    end

    // Register the command and read strobes with their payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            cmd_valid <= ev_addr_done;
            rd_valid  <= ev_ext_read;
            if (ev_addr_done) begin
                cmd_opcode <= done_op;
                cmd_addr   <= formed;
            end
            if (ev_ext_read) rd_data <= {{(BYTE_W-1){1'b0}}, ext_a24};
        end
    end

    // R9: reserved register bits read back as zero.
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[BYTE_W-1:1] == '0));

    // R3: a narrow command never carries address bits above A24.
    assert_narrow_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_done && !done_wide) |=> (cmd_addr[ADDR_W-1:LOW_W+1] == '0));

    // R11: the command strobe lasts one cycle per completed address phase.
    assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_done |=> cmd_valid);

endmodule

// File: rtl/flash_addr_ctrl.sv
// Top of the flash address mode controller: sequencer, state registers and
// output stage. Assumes a byte-level SPI front end that asserts byte_valid once per byte.
module flash_addr_ctrl #(
    parameter int BYTE_W     = 8,
    parameter int NARROW_CNT = 3,
    parameter int WIDE_CNT   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       byte_valid,
    input  logic [BYTE_W-1:0]          byte_data,
    output logic                       cmd_valid,
    output logic [BYTE_W-1:0]          cmd_opcode,
    output logic [BYTE_W*WIDE_CNT-1:0] cmd_addr,
    output logic                       rd_valid,
    output logic [BYTE_W-1:0]          rd_data,
    output logic                       addr4_mode,
    output logic                       wel
);
    localparam int ADDR_W = BYTE_W * WIDE_CNT;

    logic              ev_go_wide, ev_go_narrow, ev_set_wel, ev_clr_wel;
    logic              ev_ext_data, ev_ext_read, ev_addr_done, done_wide;
    logic [BYTE_W-1:0] done_op;
    logic [ADDR_W-1:0] done_raw;
    logic              mode_wide, wel_q, ext_a24;

    fac_seq #(.BYTE_W(BYTE_W), .NARROW_CNT(NARROW_CNT), .WIDE_CNT(WIDE_CNT)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
        .byte_data(byte_data), .mode_wide(mode_wide),
        .ev_go_wide(ev_go_wide), .ev_go_narrow(ev_go_narrow),
        .ev_set_wel(ev_set_wel), .ev_clr_wel(ev_clr_wel),
        .ev_ext_data(ev_ext_data), .ev_ext_read(ev_ext_read),
        .ev_addr_done(ev_addr_done), .done_wide(done_wide),
        .done_op(done_op), .done_raw(done_raw)
    );

    fac_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ev_go_wide(ev_go_wide), .ev_go_narrow(ev_go_narrow),
        .ev_set_wel(ev_set_wel), .ev_clr_wel(ev_clr_wel),
        .ev_ext_data(ev_ext_data), .byte_data(byte_data),
        .mode_wide(mode_wide), .wel_q(wel_q), .ext_a24(ext_a24)
    );

    fac_out #(.BYTE_W(BYTE_W), .NARROW_CNT(NARROW_CNT), .WIDE_CNT(WIDE_CNT)) u_out (
        .clk(clk), .rst_n(rst_n),
        .ev_addr_done(ev_addr_done), .done_wide(done_wide),
        .done_op(done_op), .done_raw(done_raw),
        .ev_ext_read(ev_ext_read), .ext_a24(ext_a24),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign addr4_mode = mode_wide;
    assign wel        = wel_q;

    // R1/R8: the two output strobes never coincide, since they come from distinct commands.
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && rd_valid));

endmodule

// File: tb/flash_addr_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected strobes, monitors pop and compare.
module flash_addr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cmd_valid, rd_valid, addr4_mode, wel;
    logic [7:0]  cmd_opcode, rd_data;
    logic [31:0] cmd_addr;

    int checks = 0;
    int fails  = 0;
    logic [39:0] exp_cmd[$];   // {opcode, address}
    logic [7:0]  exp_rd[$];
    string       cmd_tag[$];

    always #5 clk = ~clk;

    flash_addr_ctrl u_flash_addr_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
        .byte_data(byte_data), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .addr4_mode(addr4_mode), .wel(wel)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare every command strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_cmd.size() == 0) begin
                check("R10/R12 unexpected command", {cmd_opcode, cmd_addr}, 40'h0);
            end else begin
                check(cmd_tag.pop_front(), {cmd_opcode, cmd_addr}, exp_cmd.pop_front());
            end
        end
        if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) check("R8 unexpected read", {32'h0, rd_data}, 40'h0);
            else                    check("R8/R9 read", {32'h0, rd_data}, {32'h0, exp_rd.pop_front()});
        end
    end

    // Driver: one select window with n bytes on consecutive cycles.
    task automatic xfer(input logic [7:0] b [8], input int n);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = b[i];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        cs_n       = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_cmd(input string tag, input logic [7:0] op, input logic [31:0] a);
        exp_cmd.push_back({op, a});
        cmd_tag.push_back(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset mode/wel/strobes", {36'h0, addr4_mode, wel, cmd_valid, rd_valid}, 40'h0);
        exp_rd.push_back(8'h00);                                 // R1 extension bit is 0
        xfer('{8'hC8, 0, 0, 0, 0, 0, 0, 0}, 1);
        expect_cmd("R3/R11 narrow read", 8'h03, 32'h0012_3456);
        xfer('{8'h03, 8'h12, 8'h34, 8'h56, 0, 0, 0, 0}, 4);
        // R7: write without the latch is ignored
        xfer('{8'hC5, 8'h01, 0, 0, 0, 0, 0, 0}, 2);
        exp_rd.push_back(8'h00);
        xfer('{8'hC8, 0, 0, 0, 0, 0, 0, 0}, 1);
        // R6: latch set and cleared
        xfer('{8'h06, 0, 0, 0, 0, 0, 0, 0}, 1);
        check("R6 set latch", {39'h0, wel}, 40'h1);
        xfer('{8'h04, 0, 0, 0, 0, 0, 0, 0}, 1);
        check("R6 clear latch", {39'h0, wel}, 40'h0);
        // R7/R9: guarded write of FFh stores only bit 0
        xfer('{8'h06, 0, 0, 0, 0, 0, 0, 0}, 1);
        xfer('{8'hC5, 8'hFF, 0, 0, 0, 0, 0, 0}, 2);
        check("R7 latch cleared by write", {39'h0, wel}, 40'h0);
        exp_rd.push_back(8'h01);
        xfer('{8'hC8, 0, 0, 0, 0, 0, 0, 0}, 1);
        expect_cmd("R3 extension supplies A24", 8'h0B, 32'h01AB_CDEF);
        xfer('{8'h0B, 8'hAB, 8'hCD, 8'hEF, 0, 0, 0, 0}, 4);
        // R2: enter wide mode without the latch
        xfer('{8'hB7, 0, 0, 0, 0, 0, 0, 0}, 1);
        check("R2 enter wide", {38'h0, addr4_mode, wel}, 40'h2);
        expect_cmd("R4 wide legacy ignores extension", 8'hEB, 32'h1234_5678);
        xfer('{8'hEB, 8'h12, 8'h34, 8'h56, 8'h78, 0, 0, 0}, 5);
        // R10: truncated command dropped, then a clean command
        xfer('{8'h02, 8'hAA, 8'hBB, 0, 0, 0, 0, 0}, 3);
        check("R10 state kept after truncation", {38'h0, addr4_mode, wel}, 40'h2);
        expect_cmd("R10 recovery", 8'h03, 32'h0000_0001);
        xfer('{8'h03, 8'h00, 8'h00, 8'h00, 8'h01, 0, 0, 0}, 5);
        // R2: exit wide mode
        xfer('{8'hE9, 0, 0, 0, 0, 0, 0, 0}, 1);
        check("R2 exit wide", {38'h0, addr4_mode, wel}, 40'h0);
        expect_cmd("R5 dedicated in narrow mode", 8'h13, 32'hFEDC_BA98);
        xfer('{8'h13, 8'hFE, 8'hDC, 8'hBA, 8'h98, 0, 0, 0}, 5);
        expect_cmd("R5 dedicated erase", 8'h21, 32'h0102_0304);
        xfer('{8'h21, 8'h01, 8'h02, 8'h03, 8'h04, 0, 0, 0}, 5);
        // R12: trailing bytes and unknown opcode ignored
        expect_cmd("R12 one command despite trailing bytes", 8'h03, 32'h0111_2233);
        xfer('{8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 0}, 7);
        xfer('{8'h9F, 8'h03, 8'h00, 8'h00, 8'h00, 0, 0, 0}, 5);
        // R7: clear extension bit again
        xfer('{8'h06, 0, 0, 0, 0, 0, 0, 0}, 1);
        xfer('{8'hC5, 8'h00, 0, 0, 0, 0, 0, 0}, 2);
        exp_rd.push_back(8'h00);
        xfer('{8'hC8, 0, 0, 0, 0, 0, 0, 0}, 1);
        expect_cmd("R3 lower half after clear", 8'h03, 32'h0011_2233);
        xfer('{8'h03, 8'h11, 8'h22, 8'h33, 0, 0, 0, 0}, 4);
        // R1: reset leaves wide mode
        xfer('{8'hB7, 0, 0, 0, 0, 0, 0, 0}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset returns to narrow", {39'h0, addr4_mode}, 40'h0);
        repeat (3) @(negedge clk);
        check("R11 all commands seen", 40'(exp_cmd.size()), 40'h0);
        check("R8 all reads seen", 40'(exp_rd.size()), 40'h0);
        finish_run();
    end
endmodule